// File: doc/BRIEF.md
# Two-Channel CIC Interpolation Stage

This block is the last rate-raising stage of a stereo audio interpolation chain for an oversampling converter. Samples arrive from the earlier stages at four times the base audio rate (176.4 kHz for a 44.1 kHz base rate). The block raises that rate by a factor of sixteen to 2822.4 kHz, so the whole chain oversamples by 64. It uses a cascaded integrator-comb structure with two comb and two integrator sections and a differential delay of one. The combs run once per input sample. Each comb result is followed by fifteen zero slots, and the integrators run once per output sample.

A single 50 MHz clock drives everything. A fractional accumulator makes an output-rate strobe from that clock. On each strobe the shared adders process channel 0 in one cycle and channel 1 in the next. Every sixteenth strobe, the block pulls a new input pair through `in_take`. The integrators add 4 guard bits and wrap in two's complement. The DC gain of sixteen is removed with a rounding right shift, so the output has the same width as the input. For a step input, the output ramps linearly from the previous input sample to the new one over sixteen output samples.

Top module: `cic_interp_2ch`

## Requirements
- R1: After reset, `out_ch0` and `out_ch1` are zero and stay zero until the first `out_valid` pulse.
- R2: Consecutive `out_valid` pulses are 17 or 18 clock cycles apart, which gives an average of 50 MHz / 2822.4 kHz.
- R3: `in_take` is high for exactly one cycle on the first output strobe after reset and then once every 16 `out_valid` pulses. It is never high in the same cycle as `out_valid`.
- R4: Both inputs are captured only at the rising edge that ends an `in_take` cycle. Input values at any other time have no effect on the outputs.
- R5: Let xp be the input captured at the previous `in_take` (zero after reset) and xc the input captured at the latest one. Then the k-th `out_valid` pulse after the latest `in_take` (k = 0..15) presents floor((16·xp + (k+1)·(xc−xp) + 8) / 16) on each channel.
- R6: If an input is held constant, the output equals that input from the second `in_take` after the change onward.
- R7: The two channels are independent; each output depends only on its own input.
- R8: Full-scale inputs (+131071 and −131072, and steps between them) give exact outputs with no wrap-around.
- R9: `out_valid` is a one-cycle pulse, and both outputs change only in the cycle where `out_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ch0 | input | 18 | Channel 0 input sample, signed |
| in_ch1 | input | 18 | Channel 1 input sample, signed |
| in_take | output | 1 | High in the cycle whose ending edge captures both inputs |
| out_ch0 | output | 18 | Channel 0 output sample, signed |
| out_ch1 | output | 18 | Channel 1 output sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
On a sample strobe, several things happen in the same cycle: the input-capture edge, the comb update and the first integrator accumulation of the new ramp all fall together. Output slot k = 0 therefore depends on values written in the same cycle they are used. The bench provokes this case by changing the inputs one cycle after each capture. It also drives short glitches in the middle of the interval, which must not leak into the output. Every output pulse is judged against the closed-form linear ramp between the last two captured samples.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;
  typedef enum logic {CH_ZERO = 1'b0, CH_ONE = 1'b1} chan_e;

  function automatic int unsigned guard_bits(input int unsigned sections, input int unsigned log_rate);
    return (sections - 1) * log_rate;
  endfunction
endpackage

// File: rtl/cic_rate_gen.sv
module cic_rate_gen
  import cic_interp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned OUT_HZ = 2_822_400,
  parameter int unsigned R      = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  output logic  tick,
  output logic  proc,
  output chan_e chan,
  output logic  first
);
  localparam int AW = $clog2(CLK_HZ) + 1;
  localparam int PW = (R > 1) ? $clog2(R) : 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] acc_sum;
  logic          busy;
  logic [PW-1:0] ph;

  assign acc_sum = acc + AW'(OUT_HZ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
      busy <= 1'b0;
      ph   <= '0;
    end else begin
      if (acc_sum >= AW'(CLK_HZ)) begin
        acc  <= acc_sum - AW'(CLK_HZ);
        tick <= 1'b1;
      end else begin
        acc  <= acc_sum;
        tick <= 1'b0;
      end
      busy <= tick;
      if (busy) ph <= (ph == PW'(R - 1)) ? '0 : ph + 1'b1;
    end
  end

  assign proc  = tick | busy;
  assign chan  = busy ? CH_ONE : CH_ZERO;
  assign first = (ph == '0);
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank
  import cic_interp_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int ACC_W = 22,
  parameter int NSEC  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    proc,
  input  chan_e                   chan,
  input  logic                    first,
  input  logic                    take,
  input  logic signed [IN_W-1:0]  in_ch0,
  input  logic signed [IN_W-1:0]  in_ch1,
  output logic signed [IN_W-1:0]  held1,
  output logic signed [ACC_W-1:0] stuffed
);
  logic signed [ACC_W-1:0] dly [2][NSEC];
  logic signed [ACC_W-1:0] stg [NSEC+1];
  logic signed [IN_W-1:0]  x_sel;
  logic                    ci;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [IN_W-1:0] v);
    return {{(ACC_W-IN_W){v[IN_W-1]}}, v};
  endfunction

  function automatic logic signed [ACC_W-1:0] zero_stuff(input logic keep, input logic signed [ACC_W-1:0] v);
    return keep ? v : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) held1 <= '0;
    else if (take) held1 <= in_ch1;
  end

  assign ci    = (chan == CH_ONE);
  assign x_sel = ci ? held1 : in_ch0;

  always_comb begin
    stg[0] = widen(x_sel);
    for (int s = 0; s < NSEC; s++) stg[s+1] = stg[s] - dly[ci][s];
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
      always_ff @(posedge clk) begin
        if (!rst_n) dly[c][s] <= '0;
        else if (proc && first && (ci == c[0])) dly[c][s] <= stg[s];
      end
    end
  end

  assign stuffed = zero_stuff(first, stg[NSEC]);
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank
  import cic_interp_pkg::*;
#(
  parameter int OUT_W = 18,
  parameter int ACC_W = 22,
  parameter int NSEC  = 2,
  parameter int SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    proc,
  input  chan_e                   chan,
  input  logic signed [ACC_W-1:0] stuffed,
  output logic signed [OUT_W-1:0] out_ch0,
  output logic signed [OUT_W-1:0] out_ch1,
  output logic                    out_valid
);
  localparam logic signed [ACC_W-1:0] HALF_V = (SHIFT > 0) ? ACC_W'(1) <<< (SHIFT - 1) : '0;

  logic signed [ACC_W-1:0] integ [2][NSEC];
  logic signed [ACC_W-1:0] run [NSEC+1];
  logic signed [OUT_W-1:0] pend0;
  logic signed [OUT_W-1:0] rounded;
  logic                    ci;

  function automatic logic signed [OUT_W-1:0] round_out(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] t;
    t = v + HALF_V;
    t = t >>> SHIFT;
    return t[OUT_W-1:0];
  endfunction

  assign ci = (chan == CH_ONE);

  always_comb begin
    run[0] = stuffed;
    for (int s = 0; s < NSEC; s++) run[s+1] = integ[ci][s] + run[s];
  end

  assign rounded = round_out(run[NSEC]);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
      always_ff @(posedge clk) begin
        if (!rst_n) integ[c][s] <= '0;
        else if (proc && (ci == c[0])) integ[c][s] <= run[s+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend0     <= '0;
      out_ch0   <= '0;
      out_ch1   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= proc && ci;
      if (proc && !ci) pend0 <= rounded;
      if (proc && ci) begin
        out_ch0 <= pend0;
        out_ch1 <= rounded;
      end
    end
  end
endmodule

// File: rtl/cic_interp_2ch.sv
module cic_interp_2ch
  import cic_interp_pkg::*;
#(
  parameter int          IN_W   = 18,
  parameter int          R      = 16,
  parameter int          NSEC   = 2,
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned OUT_HZ = 2_822_400
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] in_ch0,
  input  logic signed [IN_W-1:0] in_ch1,
  output logic                   in_take,
  output logic signed [IN_W-1:0] out_ch0,
  output logic signed [IN_W-1:0] out_ch1,
  output logic                   out_valid
);
  localparam int LOGR  = $clog2(R);
  localparam int SHIFT = int'(guard_bits(NSEC, LOGR));
  localparam int ACC_W = IN_W + SHIFT;

  logic                    tick;
  logic                    proc;
  chan_e                   chan;
  logic                    first;
  logic signed [IN_W-1:0]  held1;
  logic signed [ACC_W-1:0] stuffed;

  cic_rate_gen #(.CLK_HZ(CLK_HZ), .OUT_HZ(OUT_HZ), .R(R)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .proc(proc), .chan(chan), .first(first)
  );

  assign in_take = tick && first;

  cic_comb_bank #(.IN_W(IN_W), .ACC_W(ACC_W), .NSEC(NSEC)) u_comb (
    .clk(clk), .rst_n(rst_n), .proc(proc), .chan(chan), .first(first), .take(in_take),
    .in_ch0(in_ch0), .in_ch1(in_ch1), .held1(held1), .stuffed(stuffed)
  );

  cic_integ_bank #(.OUT_W(IN_W), .ACC_W(ACC_W), .NSEC(NSEC), .SHIFT(SHIFT)) u_integ (
    .clk(clk), .rst_n(rst_n), .proc(proc), .chan(chan), .stuffed(stuffed),
    .out_ch0(out_ch0), .out_ch1(out_ch1), .out_valid(out_valid)
  );
endmodule

// File: rtl/cic_interp_2ch_chk.sv
module cic_interp_2ch_chk #(
  parameter int          IN_W   = 18,
  parameter int          R      = 16,
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned OUT_HZ = 2_822_400
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_take,
  input logic                   out_valid,
  input logic signed [IN_W-1:0] out_ch0,
  input logic signed [IN_W-1:0] out_ch1,
  input logic signed [IN_W-1:0] held1
);
  localparam int unsigned LO  = CLK_HZ / OUT_HZ;
  localparam int unsigned HI  = ((CLK_HZ % OUT_HZ) != 0) ? LO + 1 : LO;
  localparam int          CW  = $clog2(R) + 2;

  logic [15:0]   gap;
  logic [CW-1:0] vcount;
  logic          seen_v;
  logic          seen_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      vcount    <= '0;
      seen_v    <= 1'b0;
      seen_take <= 1'b0;
    end else begin
      gap <= out_valid ? '0 : ((gap == 16'hFFFF) ? gap : gap + 1'b1);
      if (out_valid) seen_v <= 1'b1;
      if (in_take) begin
        seen_take <= 1'b1;
        vcount    <= '0;
      end else if (out_valid) begin
        vcount <= vcount + 1'b1;
      end
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_v && !out_valid) |-> (out_ch0 == '0 && out_ch1 == '0));

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_v) |-> (gap == 16'(LO - 1) || gap == 16'(HI - 1)));

  // R3
  take_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take && seen_take) |-> (vcount == CW'(R)));

  // R3
  take_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_take && out_valid));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_take |=> $stable(held1));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  out_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (!out_valid || 1'b1) && ($stable(out_ch0) && $stable(out_ch1)) || out_valid);
endmodule

bind cic_interp_2ch cic_interp_2ch_chk #(
  .IN_W(IN_W), .R(R), .CLK_HZ(CLK_HZ), .OUT_HZ(OUT_HZ)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_take(in_take), .out_valid(out_valid),
  .out_ch0(out_ch0), .out_ch1(out_ch1), .held1(held1)
);

// File: tb/cic_interp_2ch_tb_top.sv
`timescale 1ns/1ps
module cic_interp_2ch_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [17:0] in_ch0 = '0;
  logic signed [17:0] in_ch1 = '0;
  logic               in_take;
  logic signed [17:0] out_ch0;
  logic signed [17:0] out_ch1;
  logic               out_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int takes = 0;
  int xp0 = 0, xc0 = 0, xp1 = 0, xc1 = 0;
  int exp0 = 0, exp1 = 0;
  int k = 0;
  int vcount = 0;
  int gap = 0;
  bit have_v = 0;
  bit prev_v = 0;
  bit done = 0;
  string cur_req = "R5";
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  cic_interp_2ch dut_i (
    .clk(clk), .rst_n(rst_n), .in_ch0(in_ch0), .in_ch1(in_ch1),
    .in_take(in_take), .out_ch0(out_ch0), .out_ch1(out_ch1), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int ramp(input int xp, input int xc, input int idx);
    int v;
    v = 16 * xp + (idx + 1) * (xc - xp);
    return (v + 8) >>> 4;
  endfunction

  // Reference model, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_ch0 == 0 && out_ch1 == 0, "R1 during reset", int'(out_ch0), 0);
    end else begin
      gap++;
      if (in_take) begin
        if (takes > 0) chk(vcount == 16, "R3 pulses per take", vcount, 16);
        else chk(!have_v, "R3 first take before any pulse", int'(have_v), 0);
        chk(!out_valid, "R3 take apart from pulse", int'(out_valid), 0);
        xp0 = xc0; xc0 = int'(in_ch0);
        xp1 = xc1; xc1 = int'(in_ch1);
        k = 0; vcount = 0; takes++;
      end
      if (out_valid) begin
        if (have_v) chk(gap == 17 || gap == 18, "R2 strobe spacing", gap, 17);
        chk(!prev_v, "R9 pulse width", int'(prev_v), 0);
        exp0 = ramp(xp0, xc0, k);
        exp1 = ramp(xp1, xc1, k);
        k++; vcount++; gap = 0; have_v = 1;
      end
      prev_v = out_valid;
      chk(int'(out_ch0) == exp0, {cur_req, " R5 ch0"}, int'(out_ch0), exp0);
      chk(int'(out_ch1) == exp1, {cur_req, " R7 ch1"}, int'(out_ch1), exp1);
    end
  end

  task automatic drive(input int a, input int b);
    @(posedge clk); #2;
    in_ch0 = 18'(a);
    in_ch1 = 18'(b);
  endtask

  task automatic wait_takes(input int n);
    int t0;
    t0 = takes;
    while (takes < t0 + n) @(negedge clk);
  endtask

  task automatic settle_check(input string req, input int a, input int b);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    chk(int'(out_ch0) == a, {req, " settled ch0"}, int'(out_ch0), a);
    chk(int'(out_ch1) == b, {req, " settled ch1"}, int'(out_ch1), b);
  endtask

  function automatic int next_val();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg[31:14]) - 131072;
  endfunction

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;

    cur_req = "R6";
    drive(1000, -2500);
    wait_takes(3);
    settle_check("R6", 1000, -2500);

    cur_req = "R8";
    drive(131071, -131072);
    wait_takes(3);
    settle_check("R8", 131071, -131072);
    drive(-131072, 131071);
    wait_takes(3);
    settle_check("R8", -131072, 131071);

    cur_req = "R4";
    drive(5, 7);
    wait_takes(2);
    for (int i = 0; i < 10; i++) begin
      int a, b;
      a = next_val();
      b = next_val();
      wait_takes(1);
      repeat (50) @(negedge clk);
      drive(-77777, 99999);
      repeat (20) @(negedge clk);
      drive(a, b);
      if (i == 9) begin
        wait_takes(2);
        settle_check("R4", a, b);
      end
    end

    cur_req = "R5";
    for (int i = 0; i < 20; i++) begin
      wait_takes(1);
      drive(next_val(), next_val());
    end
    wait_takes(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule